// File: doc/BRIEF.md
# Sideband Request Decoder

This block sits on the target side of a graphics sideband request channel. It takes in a stream of 16-bit request words, one per cycle, with a valid strobe and no back-pressure. Three of the four word kinds only refresh stored context: the command code and the address bits above bit 14. This context is kept from word to word. The fourth kind is the short word. It carries the low address bits and a length, and it produces one complete request. That request combines the short word with whatever context was stored most recently.

A complete request has a 48-bit byte address that is always 8-byte aligned, a 4-bit command and a byte count from 8 to 64. It leaves through a valid/ready port. A request is held with its payload unchanged until the consumer takes it. The consumer may hold `req_ready` low for as long as it likes. A new request may be loaded in the same cycle that the old one is taken, so back-to-back short words keep full rate. The input has no ready signal, so a short word that arrives while the output is blocked is lost, and `drop_pulse` reports the loss. A short word whose stored command lies in the reserved set is never issued. The block pulses `rsvd_err` in its place.

Top module: `sbreq_decoder`

## Requirements
- R1: A word with bit 15 = 0 is a short word. Its bits 11:0 are address bits 14:3 and its bits 14:12 are the length field. One cycle after it is captured, `req_valid` is high with `req_addr[2:0]` = 0 and `req_addr[14:3]` equal to bits 11:0.
- R2: A word with bits 15:13 = 100 stores bits 12:9 as the command and bits 8:0 as address bits 23:15. It produces no request by itself.
- R3: A word with bits 15:12 = 1010 stores bits 11:0 as address bits 35:24. A word with bits 15:12 = 1011 stores bits 11:0 as address bits 47:36.
- R4: `req_len` equals (length field + 1) × 8, which gives 8 to 64 bytes.
- R5: Reset clears the stored command and all stored address fields to zero. It also clears `req_valid`, `rsvd_err` and `drop_pulse`.
- R6: Stored fields keep their values through any number of cycles with `word_valid` low.
- R7: When the stored command is 4–7 or 12–15 (the reserved set, a parameter mask), a short word pulses `rsvd_err` for one cycle and produces no request.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_cmd` and `req_len` stay unchanged.
- R9: A non-reserved short word that arrives while the output is stalled is dropped and pulses `drop_pulse` one cycle later. Context words are still stored during a stall.
- R10: Words with bits 15:14 = 11 are ignored. They change no stored field and drive no output.
- R11: A short word that arrives in the same cycle as an output handshake is loaded without a drop, so a request can be issued every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | A request word is present this cycle |
| word_data | input | 16 | Request word |
| req_valid | output | 1 | Complete request available |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | 48 | Byte address, 8-byte aligned |
| req_cmd | output | 4 | Command code |
| req_len | output | 7 | Byte count, 8 to 64 |
| rsvd_err | output | 1 | One-cycle pulse: short word with a reserved command |
| drop_pulse | output | 1 | One-cycle pulse: short word lost to a stalled output |

## Verification
The bench sweeps all eight length codes and all sixteen command codes. A wrong length formula would give a byte count that is off by 8. A wrong reserved mask would issue a forbidden command or raise an error on a legal one. Each context word is written and then read back through a later short word, both after a long idle gap and after a reset in the middle of the run. A design that lost or failed to clear its stored context would show stale or zero upper address bits. The stall test checks several cases: the held request must not be overwritten by a short word that arrives during the stall, that word must raise a drop, and a context update made during the stall must show in the next request. A back-to-back pair of short words with `req_ready` high catches a design that reports a false drop when a load coincides with a handshake.

// File: rtl/sbreq_pkg.sv
package sbreq_pkg;
  localparam int WORD_W       = 16;
  localparam int ALIGN_W      = 3;
  localparam int LEN_FIELD_W  = 3;
  localparam int SHORT_ADDR_W = 12;
  localparam int CMD_W        = 4;
  localparam int MID_ADDR_W   = 9;
  localparam int HI_SEG_W     = 12;
  localparam int NUM_HI_SEG   = 2;
  localparam int UPPER_W      = MID_ADDR_W + NUM_HI_SEG * HI_SEG_W;
  localparam int ADDR_W       = ALIGN_W + SHORT_ADDR_W + UPPER_W;
  localparam int BYTES_W      = LEN_FIELD_W + 1 + ALIGN_W;
  localparam int NUM_CMDS     = 1 << CMD_W;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_SHORT,
    WK_CMD,
    WK_MID,
    WK_HIGH
  } word_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [CMD_W-1:0]   cmd;
    logic [BYTES_W-1:0] bytes;
  } req_t;
endpackage

// File: rtl/sbreq_word_parse.sv
module sbreq_word_parse
  import sbreq_pkg::*;
(
  input  logic                    valid,
  input  logic [WORD_W-1:0]       word,
  output word_kind_e              kind,
  output logic [SHORT_ADDR_W-1:0] short_addr,
  output logic [LEN_FIELD_W-1:0]  len_field,
  output logic [CMD_W-1:0]        cmd,
  output logic [MID_ADDR_W-1:0]   mid_addr,
  output logic [HI_SEG_W-1:0]     hi_seg
);
  localparam int TOP = WORD_W - 1;

  always_comb begin
    kind = WK_NONE;
    if (valid) begin
      if (!word[TOP])                    kind = WK_SHORT;
      else if (word[TOP-1:TOP-2] == 2'b00) kind = WK_CMD;
      else if (word[TOP-1:TOP-3] == 3'b010) kind = WK_MID;
      else if (word[TOP-1:TOP-3] == 3'b011) kind = WK_HIGH;
      else                               kind = WK_NONE;
    end
  end

  assign short_addr = word[SHORT_ADDR_W-1:0];
  assign len_field  = word[SHORT_ADDR_W +: LEN_FIELD_W];
  assign mid_addr   = word[MID_ADDR_W-1:0];
  assign cmd        = word[MID_ADDR_W +: CMD_W];
  assign hi_seg     = word[HI_SEG_W-1:0];
endmodule

// File: rtl/sbreq_sticky.sv
module sbreq_sticky
  import sbreq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  word_kind_e            kind,
  input  logic [CMD_W-1:0]      cmd_in,
  input  logic [MID_ADDR_W-1:0] mid_in,
  input  logic [HI_SEG_W-1:0]   hi_in,
  output logic [CMD_W-1:0]      cmd_q,
  output logic [UPPER_W-1:0]    upper_q
);
  logic [MID_ADDR_W-1:0]                 mid_q;
  logic [NUM_HI_SEG-1:0][HI_SEG_W-1:0]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      mid_q <= '0;
    end else if (kind == WK_CMD) begin
      cmd_q <= cmd_in;
      mid_q <= mid_in;
    end
  end

  for (genvar g = 0; g < NUM_HI_SEG; g++) begin : g_hi
    logic sel;
    assign sel = (g == 0) ? (kind == WK_MID) : (kind == WK_HIGH);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_q[g] <= '0;
      else if (sel) hi_q[g] <= hi_in;
    end
  end

  assign upper_q = {hi_q, mid_q};
endmodule

// File: rtl/sbreq_out_stage.sv
module sbreq_out_stage
  import sbreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  req_t req_in,
  input  logic ready,
  output logic valid,
  output req_t req_q,
  output logic drop_q
);
  logic can_load;
  assign can_load = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      req_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      drop_q <= load && !can_load;
      if (load && can_load) begin
        valid <= 1'b1;
        req_q <= req_in;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbreq_decoder.sv
module sbreq_decoder
  import sbreq_pkg::*;
#(
  parameter logic [NUM_CMDS-1:0] RSVD_CMD_MASK = 16'hF0F0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_valid,
  input  logic [WORD_W-1:0]    word_data,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [CMD_W-1:0]     req_cmd,
  output logic [BYTES_W-1:0]   req_len,
  output logic                 rsvd_err,
  output logic                 drop_pulse
);
  word_kind_e              kind;
  logic [SHORT_ADDR_W-1:0] short_addr;
  logic [LEN_FIELD_W-1:0]  len_field;
  logic [CMD_W-1:0]        cmd_w;
  logic [MID_ADDR_W-1:0]   mid_w;
  logic [HI_SEG_W-1:0]     hi_w;
  logic [CMD_W-1:0]        cmd_q;
  logic [UPPER_W-1:0]      upper_q;
  logic                    is_short, is_rsvd, load;
  req_t                    req_new, req_q;

  sbreq_word_parse u_parse (
    .valid(word_valid), .word(word_data), .kind(kind),
    .short_addr(short_addr), .len_field(len_field), .cmd(cmd_w),
    .mid_addr(mid_w), .hi_seg(hi_w)
  );

  sbreq_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .kind(kind), .cmd_in(cmd_w),
    .mid_in(mid_w), .hi_in(hi_w), .cmd_q(cmd_q), .upper_q(upper_q)
  );

  assign is_short = (kind == WK_SHORT);
  assign is_rsvd  = RSVD_CMD_MASK[cmd_q];
  assign load     = is_short && !is_rsvd;

  always_comb begin
    req_new.addr  = {upper_q, short_addr, {ALIGN_W{1'b0}}};
    req_new.cmd   = cmd_q;
    req_new.bytes = {{1'b0, len_field} + {{LEN_FIELD_W{1'b0}}, 1'b1}, {ALIGN_W{1'b0}}};
  end

  sbreq_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .req_in(req_new),
    .ready(req_ready), .valid(req_valid), .req_q(req_q), .drop_q(drop_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsvd_err <= 1'b0;
    else        rsvd_err <= is_short && is_rsvd;
  end

  assign req_addr = req_q.addr;
  assign req_cmd  = req_q.cmd;
  assign req_len  = req_q.bytes;
endmodule

// File: rtl/sbreq_decoder_chk.sv
module sbreq_decoder_chk
  import sbreq_pkg::*;
#(
  parameter logic [NUM_CMDS-1:0] RSVD_CMD_MASK = 16'hF0F0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                word_valid,
  input logic [WORD_W-1:0]   word_data,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [CMD_W-1:0]    req_cmd,
  input logic [BYTES_W-1:0]  req_len,
  input logic                rsvd_err,
  input logic                drop_pulse
);
  assert_addr_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[ALIGN_W-1:0] == '0);

  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len >= 7'd8 && req_len <= 7'd64 && req_len[ALIGN_W-1:0] == '0));

  assert_no_rsvd_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !RSVD_CMD_MASK[req_cmd]);

  assert_err_from_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_err |-> $past(word_valid && !word_data[WORD_W-1]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_cmd) && $stable(req_len));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(req_valid && !req_ready));

  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_data[WORD_W-1:WORD_W-2] == 2'b11 && (!req_valid || req_ready)
      |=> !req_valid && !rsvd_err && !drop_pulse);

  assert_full_rate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !drop_pulse);
endmodule

bind sbreq_decoder sbreq_decoder_chk #(.RSVD_CMD_MASK(RSVD_CMD_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_cmd(req_cmd), .req_len(req_len), .rsvd_err(rsvd_err), .drop_pulse(drop_pulse)
);

// File: tb/sbreq_decoder_tb.sv
module sbreq_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RSVD = 16'hF0F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        req_ready = 1'b1;
  logic        req_valid, rsvd_err, drop_pulse;
  logic [47:0] req_addr;
  logic [3:0]  req_cmd;
  logic [6:0]  req_len;

  int n_tests = 0;
  int n_fail  = 0;

  logic [3:0]  m_cmd;
  logic [8:0]  m_mid;
  logic [11:0] m_h3, m_h4;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbreq_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_len(req_len), .rsvd_err(rsvd_err), .drop_pulse(drop_pulse)
  );

  function automatic logic [15:0] w_short(input logic [2:0] len, input logic [11:0] a);
    return {1'b0, len, a};
  endfunction
  function automatic logic [15:0] w_cmd(input logic [3:0] c, input logic [8:0] a);
    return {3'b100, c, a};
  endfunction
  function automatic logic [15:0] w_mid(input logic [11:0] a);
    return {4'b1010, a};
  endfunction
  function automatic logic [15:0] w_high(input logic [11:0] a);
    return {4'b1011, a};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_req(input string tag, input logic [11:0] a, input logic [2:0] len);
    chk({tag, " valid"}, 64'(req_valid), 64'd1);
    chk({tag, " addr"}, 64'(req_addr), 64'({m_h4, m_h3, m_mid, a, 3'b000}));
    chk({tag, " cmd"}, 64'(req_cmd), 64'(m_cmd));
    chk({tag, " len"}, 64'(req_len), 64'((int'(len) + 1) * 8));
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = w;
    if (w[15:13] == 3'b100) begin m_cmd = w[12:9]; m_mid = w[8:0]; end
    if (w[15:12] == 4'b1010) m_h3 = w[11:0];
    if (w[15:12] == 4'b1011) m_h4 = w[11:0];
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_cmd = '0; m_mid = '0; m_h3 = '0; m_h4 = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R5: reset state of outputs
    chk("R5 valid after reset", 64'(req_valid), 64'd0);
    chk("R5 err after reset", 64'(rsvd_err), 64'd0);
    chk("R5 drop after reset", 64'(drop_pulse), 64'd0);
    // R5 / R1: first short word sees cleared context
    put(w_short(3'd3, 12'hABC));
    chk_req("R5 R1 cleared context", 12'hABC, 3'd3);

    // R4 / R1: sweep all length codes
    for (int l = 0; l < 8; l++) begin
      logic [11:0] a;
      a = 12'(l * 12'h1F3 + 12'h05A);
      put(w_short(3'(l), a));
      chk_req("R4 R1 length sweep", a, 3'(l));
    end

    // R3: upper segments
    put(w_mid(12'h5A5));
    put(w_high(12'hC3C));
    put(w_short(3'd7, 12'h001));
    chk_req("R3 upper segments", 12'h001, 3'd7);

    // R2 / R7: sweep all commands
    for (int c = 0; c < 16; c++) begin
      logic [8:0] a9;
      a9 = 9'((c * 37 + 11) & 9'h1FF);
      put(w_cmd(4'(c), a9));
      chk("R2 context word silent", 64'(req_valid), 64'd0);
      put(w_short(3'(c), 12'(c * 255)));
      if (RSVD[c]) begin
        chk("R7 reserved err", 64'(rsvd_err), 64'd1);
        chk("R7 reserved no request", 64'(req_valid), 64'd0);
      end else begin
        chk("R7 legal no err", 64'(rsvd_err), 64'd0);
        chk_req("R2 command sweep", 12'(c * 255), 3'(c));
      end
    end
    put(w_cmd(4'd2, 9'h155));

    // R6: long idle gap keeps context
    idle(60);
    put(w_short(3'd1, 12'h777));
    chk_req("R6 persist after idle", 12'h777, 3'd1);

    // R10: reserved-prefix words ignored
    for (int k = 0; k < 4; k++) begin
      put(16'(16'hC000 | (k << 12) | (k * 16'h0123)));
      chk("R10 ignored no request", 64'(req_valid), 64'd0);
      chk("R10 ignored no err", 64'(rsvd_err), 64'd0);
    end
    put(w_short(3'd2, 12'h246));
    chk_req("R10 context unchanged", 12'h246, 3'd2);
    idle(1);

    // R8 / R9: stall
    req_ready = 1'b0;
    put(w_short(3'd4, 12'h111));
    chk_req("R8 stalled request", 12'h111, 3'd4);
    idle(3);
    chk_req("R8 held during stall", 12'h111, 3'd4);
    put(w_short(3'd5, 12'h222));
    chk("R9 drop pulse", 64'(drop_pulse), 64'd1);
    chk("R9 held addr after drop", 64'(req_addr), 64'({m_h4, m_h3, m_mid, 12'h111, 3'b000}));
    put(w_mid(12'h9E1));
    chk("R9 drop one cycle", 64'(drop_pulse), 64'd0);
    chk("R9 still held", 64'(req_len), 64'd40);
    req_ready = 1'b1;
    idle(1);
    chk("R8 released", 64'(req_valid), 64'd0);
    put(w_short(3'd0, 12'h333));
    chk_req("R9 context updated in stall", 12'h333, 3'd0);
    idle(1);

    // R11: back-to-back short words with ready high
    @(negedge clk);
    word_valid = 1'b1; word_data = w_short(3'd6, 12'h404);
    @(negedge clk);
    chk_req("R11 first of pair", 12'h404, 3'd6);
    word_data = w_short(3'd2, 12'h505);
    @(negedge clk);
    word_valid = 1'b0;
    chk_req("R11 second of pair", 12'h505, 3'd2);
    chk("R11 no drop", 64'(drop_pulse), 64'd0);
    idle(1);

    // R5: reset in mid run clears context
    do_reset();
    put(w_short(3'd7, 12'hFFF));
    chk_req("R5 mid-run reset clears", 12'hFFF, 3'd7);
    chk("R5 upper zero", 64'(req_addr[47:15]), 64'd0);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule